// File: doc/BRIEF.md
# Two-Class Error and Attention Reporter

This block collects sixteen single-cycle error pulses from the detectors of a tape formatter into a sticky error register and derives a composite error flag from it. It sorts the errors into two classes. The hard class ends a transfer that is in progress, through an abort request. The soft class is only recorded and lets the transfer run on.

The block has two signalling paths. An error raised while a data transfer is running drives the exception line in the same cycle. An error raised while no command is active, or while a rewind is running, raises attention. A non-transfer command that completes, or a change in the status of a tape unit, also raises attention. The attention bit of this unit sits in a summary word that is shared by up to eight units. A summary write with a 1 in this unit's position clears the bit. A summary read drives only this unit's line and leaves the other lines released.

A drive-clear pulse wipes the error register and the attention bit. The detectors themselves are outside the block.

Top module: `err_attn_top`

## Requirements
- R1: An error pulse on line i sets bit i of `err_reg_o` one cycle later. Set bits stay set until a drive clear. All bits are 0 after reset.
- R2: `drv_clr_i` clears `err_reg_o` and `ata_o` on the next cycle. It wins over error pulses and attention events in the same cycle.
- R3: `err_o` is 1 exactly when at least one bit of `err_reg_o` is 1.
- R4: `abort_o` is 1 in a cycle exactly when `xfer_i` is high and a hard-class error is pulsing or stored. The hard-class bits are 0, 4, 11, 12, 13 and 14 (mask 16'h7811). Soft-class bits never raise `abort_o`.
- R5: `exc_o` is 1 in a cycle exactly when `xfer_i` is high and any error is pulsing or stored. This holds in the same cycle as the pulse.
- R6: An error pulse while `go_i` is low or `rewind_i` is high raises `attn_o` in the same cycle and sets `ata_o` on the next cycle.
- R7: A `cmd_done_i` or `slave_chg_i` pulse raises `attn_o` in the same cycle and sets `ata_o` on the next cycle.
- R8: A summary write whose data has a 1 at bit `unit_id_i` clears `ata_o` on the next cycle. A 0 at that bit leaves `ata_o` unchanged, whatever the other bits hold.
- R9: An attention event in the same cycle as a clearing summary write leaves `ata_o` set.
- R10: While `as_rd_i` is high, `as_rd_oe_o` has exactly bit `unit_id_i` set, and `as_rd_data_o` carries `ata_o` at that bit and 0 elsewhere. While `as_rd_i` is low, both outputs are 0.
- R11: An error pulse while `go_i` is high and `rewind_i` is low does not raise `attn_o` and does not set `ata_o`.
- R12: `attn_o` is high in every cycle in which `ata_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_pulse_i | input | 16 | One line per error condition, one-cycle pulses |
| go_i | input | 1 | A command is active |
| xfer_i | input | 1 | A data transfer is in progress |
| rewind_i | input | 1 | A rewind is in progress |
| cmd_done_i | input | 1 | A non-transfer command has completed |
| slave_chg_i | input | 1 | The status of a tape unit has changed |
| drv_clr_i | input | 1 | Drive-clear pulse |
| unit_id_i | input | 3 | Unit number of this formatter |
| as_wr_i | input | 1 | Summary write strobe |
| as_wdata_i | input | 16 | Summary write data |
| as_rd_i | input | 1 | Summary read strobe |
| err_reg_o | output | 16 | Sticky error register |
| err_o | output | 1 | Composite error flag |
| ata_o | output | 1 | Stored attention bit |
| exc_o | output | 1 | Exception during a transfer |
| attn_o | output | 1 | Attention line |
| abort_o | output | 1 | Request to end the transfer |
| as_rd_data_o | output | 16 | Summary read data |
| as_rd_oe_o | output | 16 | Per-line drive enable for the summary read |

## Verification
Error pulses go in with every combination of transfer, command-active and rewind state. Soft-only patterns tell exception apart from abort. Hard-class patterns show which of the six positions end a transfer. Idle and rewind errors, set against errors during an active command, separate the attention path from the exception path. Summary writes are tried with the unit's own bit, with only foreign bits, and in the same cycle as new events, which tells clear, ignore and set-wins apart. Summary reads are tried from every unit number. A drive clear that lands on pending pulses shows which side has priority.

// File: rtl/err_attn_pkg.sv
package err_attn_pkg;
  localparam int unsigned ERR_W  = 16;
  localparam int unsigned SUM_W  = 16;
  localparam int unsigned UNIT_W = 3;
  // hard class: bits 0,4,11,12,13,14
  localparam logic [ERR_W-1:0] HARD_MASK = 16'h7811;

  typedef struct packed {
    logic set;
    logic clr;
    logic wipe;
  } ata_ctl_t;
endpackage

// File: rtl/err_collect.sv
module err_collect
  import err_attn_pkg::*;
#(
  parameter int unsigned W = ERR_W,
  parameter logic [W-1:0] HARD = HARD_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pulse_i,
  input  logic         drv_clr_i,
  input  logic         xfer_i,
  output logic [W-1:0] err_q_o,
  output logic         any_o,
  output logic         new_any_o,
  output logic         exc_o,
  output logic         abort_o
);
  logic [W-1:0] err_q;
  logic [W-1:0] live;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        err_q[g] <= 1'b0;
      else if (drv_clr_i) err_q[g] <= 1'b0;
      else if (pulse_i[g]) err_q[g] <= 1'b1;
    end
  end

  assign live      = err_q | pulse_i;
  assign err_q_o   = err_q;
  assign any_o     = |err_q;
  assign new_any_o = |pulse_i;
  assign exc_o     = xfer_i & (|live);
  assign abort_o   = xfer_i & (|(live & HARD));

  // R1
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R2
  wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_clr_i |=> (err_q == '0));
  // R4
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |-> !abort_o);
  // R5
  abort_implies_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> exc_o);
endmodule

// File: rtl/attn_ctrl.sv
module attn_ctrl
  import err_attn_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ata_ctl_t ctl_i,
  output logic     ata_o,
  output logic     attn_o
);
  logic ata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ata_q <= 1'b0;
    else if (ctl_i.wipe) ata_q <= 1'b0;
    else if (ctl_i.set)  ata_q <= 1'b1;  // new event beats w1c
    else if (ctl_i.clr)  ata_q <= 1'b0;
  end

  assign ata_o  = ata_q;
  assign attn_o = ata_q | ctl_i.set;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.set && !ctl_i.wipe) |=> ata_o);
  // R2
  ata_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.wipe |=> !ata_o);
  // R8
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.clr && !ctl_i.set) |=> !ata_o);
  // R12
  attn_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ata_o |-> attn_o);
endmodule

// File: rtl/summ_port.sv
module summ_port
  import err_attn_pkg::*;
#(
  parameter int unsigned W  = SUM_W,
  parameter int unsigned UW = UNIT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [UW-1:0] unit_i,
  input  logic          ata_i,
  output logic [W-1:0]  data_o,
  output logic [W-1:0]  oe_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic mine;
    assign mine      = rd_i && (32'(unit_i) == g);
    assign oe_o[g]   = mine;
    assign data_o[g] = mine & ata_i;
  end

  // R10
  one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_o));
  // R10
  no_float_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o & ~oe_o) == '0);
endmodule

// File: rtl/err_attn_top.sv
module err_attn_top
  import err_attn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_W-1:0]  err_pulse_i,
  input  logic              go_i,
  input  logic              xfer_i,
  input  logic              rewind_i,
  input  logic              cmd_done_i,
  input  logic              slave_chg_i,
  input  logic              drv_clr_i,
  input  logic [UNIT_W-1:0] unit_id_i,
  input  logic              as_wr_i,
  input  logic [SUM_W-1:0]  as_wdata_i,
  input  logic              as_rd_i,
  output logic [ERR_W-1:0]  err_reg_o,
  output logic              err_o,
  output logic              ata_o,
  output logic              exc_o,
  output logic              attn_o,
  output logic              abort_o,
  output logic [SUM_W-1:0]  as_rd_data_o,
  output logic [SUM_W-1:0]  as_rd_oe_o
);
  logic     new_err;
  ata_ctl_t ctl;

  err_collect #(.W(ERR_W), .HARD(HARD_MASK)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (err_pulse_i),
    .drv_clr_i (drv_clr_i),
    .xfer_i    (xfer_i),
    .err_q_o   (err_reg_o),
    .any_o     (err_o),
    .new_any_o (new_err),
    .exc_o     (exc_o),
    .abort_o   (abort_o)
  );

  assign ctl.set  = (new_err & (~go_i | rewind_i)) | cmd_done_i | slave_chg_i;
  assign ctl.clr  = as_wr_i & as_wdata_i[unit_id_i];
  assign ctl.wipe = drv_clr_i;

  attn_ctrl u_attn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .ata_o  (ata_o),
    .attn_o (attn_o)
  );

  summ_port #(.W(SUM_W), .UW(UNIT_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (as_rd_i),
    .unit_i (unit_id_i),
    .ata_i  (ata_o),
    .data_o (as_rd_data_o),
    .oe_o   (as_rd_oe_o)
  );

  // R11
  busy_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !rewind_i && !cmd_done_i && !slave_chg_i && !ata_o) |-> !attn_o);
  // R3
  flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == ($countones(err_reg_o) != 0));
endmodule

// File: tb/err_attn_top_test.sv
module err_attn_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pulse = '0;
  logic        go = 0, xfer = 0, rew = 0, done = 0, chg = 0, dclr = 0;
  logic [2:0]  unit = 3'd2;
  logic        as_wr = 0, as_rd = 0;
  logic [15:0] as_wd = '0;
  logic [15:0] err_reg, rd_data, rd_oe;
  logic        err, ata, exc, attn, abort_r;

  int total = 0, bad = 0;
  logic [15:0] m_err = '0;
  bit          m_ata = 0;
  int          hard_bits[$] = '{0, 4, 11, 12, 13, 14};

  always #5 clk = ~clk;

  err_attn_top uut (
    .clk_i(clk), .rst_ni(rst_n), .err_pulse_i(pulse), .go_i(go), .xfer_i(xfer),
    .rewind_i(rew), .cmd_done_i(done), .slave_chg_i(chg), .drv_clr_i(dclr),
    .unit_id_i(unit), .as_wr_i(as_wr), .as_wdata_i(as_wd), .as_rd_i(as_rd),
    .err_reg_o(err_reg), .err_o(err), .ata_o(ata), .exc_o(exc), .attn_o(attn),
    .abort_o(abort_r), .as_rd_data_o(rd_data), .as_rd_oe_o(rd_oe)
  );

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit is_hard(int b);
    foreach (hard_bits[k]) if (hard_bits[k] == b) return 1;
    return 0;
  endfunction

  // one cycle: inputs already set after a negedge; compare, then advance model
  task automatic step();
    logic [15:0] live;
    bit any_live, hard_live, ev;
    logic [15:0] e_oe, e_dat;
    #2;
    live = m_err | pulse;
    any_live = (live != 0);
    hard_live = 0;
    for (int b = 0; b < 16; b++) if (live[b] && is_hard(b)) hard_live = 1;
    ev = ((pulse != 0) && (!go || rew)) || done || chg;
    e_oe = '0; e_dat = '0;
    if (as_rd) begin
      e_oe[unit] = 1'b1;
      e_dat[unit] = m_ata;
    end
    chk("R1", "err_reg", err_reg, m_err);
    chk("R3", "err", 16'(err), 16'(m_err != 0));
    chk("R8", "ata", 16'(ata), 16'(m_ata));
    chk("R5", "exc", 16'(exc), 16'(xfer && any_live));
    chk("R4", "abort", 16'(abort_r), 16'(xfer && hard_live));
    chk("R6", "attn", 16'(attn), 16'(m_ata || ev));
    chk("R10", "rd_oe", rd_oe, e_oe);
    chk("R10", "rd_data", rd_data, e_dat);
    @(posedge clk);
    if (dclr) begin
      m_err = '0;
      m_ata = 0;
    end else begin
      m_err = m_err | pulse;
      if (ev) m_ata = 1;
      else if (as_wr && as_wd[unit]) m_ata = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    pulse = '0; done = 0; chg = 0; dclr = 0; as_wr = 0; as_wd = '0; as_rd = 0;
  endtask

  task automatic tick();
    step();
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    step();                     // reset state, R1 R3 R10
    rst_n = 1'b1;
    @(negedge clk);
    tick();
    // R6: soft error while idle raises attention
    pulse = 16'h0002; tick(); tick();
    as_rd = 1; tick();          // R10 read while set
    // R8: foreign bits only, no clear
    as_wr = 1; as_wd = 16'hFFFB; tick(); tick();
    // R8: own bit clears
    as_wr = 1; as_wd = 16'h0004; tick(); tick();
    // R2: drive clear, also beats a coincident pulse and event
    pulse = 16'h8000; done = 1; dclr = 1; tick(); tick();
    // R11 R5: soft error during transfer -> exc, no abort, no attention
    go = 1; xfer = 1; tick();
    pulse = 16'h0100; tick(); tick();
    // R4: each hard bit aborts while transferring
    foreach (hard_bits[k]) begin
      dclr = 1; tick();
      pulse = 16'(1 << hard_bits[k]); tick(); tick();
    end
    // R4: all soft bits together, no abort
    dclr = 1; tick();
    pulse = ~16'h7811; tick(); tick();
    xfer = 0; tick();           // stored errors, no transfer: no exc
    // R6: rewind error sets attention even with go high
    rew = 1; pulse = 16'h0040; tick(); rew = 0; tick();
    dclr = 1; tick();
    // R7: completion and status change
    go = 0; done = 1; tick(); tick();
    as_wr = 1; as_wd = 16'h0004; tick();
    chg = 1; tick(); tick();
    // R9: event coincides with w1c, stays set
    as_wr = 1; as_wd = 16'hFFFF; chg = 1; tick(); tick();
    as_wr = 1; as_wd = 16'hFFFF; pulse = 16'h0001; tick(); tick();
    // R10 R12: every unit number, read and clear
    for (int u = 0; u < 8; u++) begin
      unit = 3'(u);
      as_rd = 1; done = 1; tick();
      as_rd = 1; tick();
      as_wr = 1; as_wd = 16'(1 << u); tick();
      as_rd = 1; tick();
    end
    // R1: accumulate several bits, sticky across idle
    go = 1; pulse = 16'h00F0; tick(); pulse = 16'h0F00; tick(); tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule